// File: doc/BRIEF.md
# Address Translation Window Table

This block holds a small table of address translation windows placed between two bus domains. Software fills each window through a plain 32-bit register port: an enable bit, a size exponent, a 64-bit source base, a 64-bit destination base and a 32-bit attribute word. Every incoming request address is compared against all windows at once. The lowest-numbered enabled window that contains the address is chosen. The block then returns the remapped address, that window's attribute word, the window index and a hit flag.

A request is taken under a valid/ready handshake and its answer appears from a single output register one cycle later. The answer is held there until the consumer takes it. When no window matches, the request address is passed out unchanged with the hit flag low. This lets a miss be routed to a default target or flagged as an error further downstream.

Top module: `addr_xlat_table`

## Requirements
- R1: A synchronous active-high reset clears every window, so every table register reads 0 and no window matches.
- R2: Window i occupies byte offsets 0x20*i to 0x20*i+0x1F. Within a window, 0x00 is the source low word, 0x04 the source high word, 0x08 the destination low word, 0x0C the destination high word and 0x10 the attribute word. All five read back what was stored. Any other offset reads 0 and ignores writes.
- R3: In the source low word, bit 0 is the enable, bits 6:1 are the size field f, bits 11:7 read as 0 and bits 31:12 are base bits 31:12. In the destination low word, bits 11:0 read as 0.
- R4: A window with size field f spans 2^(f+1) bytes. An address falls inside it when all address bits above bit f equal the matching bits of the source base.
- R5: A window whose enable is 0 never matches.
- R6: On a hit, the output address takes its bits above f from the destination base and its bits f..0 from the request. The output attribute is the window's attribute word.
- R7: When several enabled windows match, the lowest-numbered one wins, and its index is reported.
- R8: On a miss, the hit flag is 0, the address is passed out unchanged, and both the attribute and the index are 0.
- R9: The size field reaches window sizes of 8 GiB (f=32) and larger. f=63 covers the whole 64-bit space.
- R10: req_ready equals (not rsp_valid) or rsp_ready. An accepted request yields rsp_valid on the next clock edge. While rsp_valid is high and rsp_ready is low, the response fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte address |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken by consumer |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the matching window |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_attr | output | 32 | Attribute word of the matching window |

## Verification
The assertions assume that the table is not rewritten in the same cycle as an accepted lookup whose answer is being checked. The assertions also assume that the consumer drives rsp_ready to a known value in every cycle. The directed stimulus programs all windows before it issues lookups, and it changes the table only between lookups. The stall scenario drops rsp_ready for a set number of cycles, and during that time it changes req_addr to show that the held answer does not follow the new address.

// File: rtl/axt_pkg.sv
package axt_pkg;
    localparam int NUM_WIN   = 8;
    localparam int ADDR_W    = 64;
    localparam int DATA_W    = 32;
    localparam int ATTR_W    = 32;
    localparam int SIZE_W    = 6;
    localparam int PAGE_LSB  = 12;
    localparam int IDX_W     = $clog2(NUM_WIN);
    localparam int SLOT_BITS = 5;
    localparam int REG_AW    = IDX_W + SLOT_BITS;
    localparam int RSV_W     = PAGE_LSB - SIZE_W - 1;

    localparam logic [SLOT_BITS-1:0] SLOT_SRC_LO = 5'h00;
    localparam logic [SLOT_BITS-1:0] SLOT_SRC_HI = 5'h04;
    localparam logic [SLOT_BITS-1:0] SLOT_DST_LO = 5'h08;
    localparam logic [SLOT_BITS-1:0] SLOT_DST_HI = 5'h0C;
    localparam logic [SLOT_BITS-1:0] SLOT_ATTR   = 5'h10;

    typedef struct packed {
        logic                         en;
        logic [SIZE_W-1:0]            sz;
        logic [ADDR_W-1:PAGE_LSB]     src;
        logic [ADDR_W-1:PAGE_LSB]     dst;
        logic [ATTR_W-1:0]            attr;
    } win_t;

    typedef struct packed {
        logic                 hit;
        logic [IDX_W-1:0]     win;
        logic [ADDR_W-1:0]    addr;
        logic [ATTR_W-1:0]    attr;
    } xlat_rsp_t;

    function automatic logic [ADDR_W-1:0] offset_mask(input logic [SIZE_W-1:0] f);
        return ({{(ADDR_W-1){1'b0}}, 1'b1} << f << 1) - 1'b1;
    endfunction

    function automatic logic [ADDR_W-1:0] page_to_addr(input logic [ADDR_W-1:PAGE_LSB] p);
        return {p, {PAGE_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/axt_regfile.sv
module axt_regfile
    import axt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [REG_AW-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [REG_AW-1:0]        raddr,
    output logic [DATA_W-1:0]        rdata,
    output win_t [NUM_WIN-1:0]       tbl
);
    logic [IDX_W-1:0]     w_idx;
    logic [SLOT_BITS-1:0] w_slot;
    logic [IDX_W-1:0]     r_idx;
    logic [SLOT_BITS-1:0] r_slot;

    assign w_idx  = waddr[REG_AW-1:SLOT_BITS];
    assign w_slot = waddr[SLOT_BITS-1:0];
    assign r_idx  = raddr[REG_AW-1:SLOT_BITS];
    assign r_slot = raddr[SLOT_BITS-1:0];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[i] <= '0;
            end else if (wr && w_idx == IDX_W'(i)) begin
                case (w_slot)
                    SLOT_SRC_LO: begin
                        tbl[i].en                     <= wdata[0];
                        tbl[i].sz                     <= wdata[SIZE_W:1];
                        tbl[i].src[DATA_W-1:PAGE_LSB] <= wdata[DATA_W-1:PAGE_LSB];
                    end
                    SLOT_SRC_HI: tbl[i].src[ADDR_W-1:DATA_W] <= wdata;
                    SLOT_DST_LO: tbl[i].dst[DATA_W-1:PAGE_LSB] <= wdata[DATA_W-1:PAGE_LSB];
                    SLOT_DST_HI: tbl[i].dst[ADDR_W-1:DATA_W] <= wdata;
                    SLOT_ATTR:   tbl[i].attr <= wdata;
                    default: ;
                endcase
            end
        end

        // R2/R3: a write to the source low word sets the enable from bit 0
        a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
            (wr && w_idx == IDX_W'(i) && w_slot == SLOT_SRC_LO) |=> (tbl[i].en == $past(wdata[0])));
    end

    always_comb begin
        rdata = '0;
        case (r_slot)
            SLOT_SRC_LO: rdata = {tbl[r_idx].src[DATA_W-1:PAGE_LSB], {RSV_W{1'b0}},
                                  tbl[r_idx].sz, tbl[r_idx].en};
            SLOT_SRC_HI: rdata = tbl[r_idx].src[ADDR_W-1:DATA_W];
            SLOT_DST_LO: rdata = {tbl[r_idx].dst[DATA_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
            SLOT_DST_HI: rdata = tbl[r_idx].dst[ADDR_W-1:DATA_W];
            SLOT_ATTR:   rdata = tbl[r_idx].attr;
            default:     rdata = '0;
        endcase
    end

    // R1: reset leaves every window disabled
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (tbl[0].en == 1'b0 && tbl[NUM_WIN-1].en == 1'b0 && tbl[0].attr == '0));
endmodule

// File: rtl/axt_match.sv
module axt_match
    import axt_pkg::*;
(
    input  logic                      en,
    input  logic [SIZE_W-1:0]         sz,
    input  logic [ADDR_W-1:PAGE_LSB]  src,
    input  logic [ADDR_W-1:PAGE_LSB]  dst,
    input  logic [ADDR_W-1:0]         addr,
    output logic                      hit,
    output logic [ADDR_W-1:0]         xaddr
);
    logic [ADDR_W-1:0] m;

    assign m     = offset_mask(sz);
    assign hit   = en && ((addr & ~m) == (page_to_addr(src) & ~m));
    assign xaddr = (page_to_addr(dst) & ~m) | (addr & m);
endmodule

// File: rtl/axt_pick.sv
module axt_pick
    import axt_pkg::*;
(
    input  logic [NUM_WIN-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/addr_xlat_table.sv
module addr_xlat_table
    import axt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_waddr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [REG_AW-1:0]    reg_raddr,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic                 rsp_hit,
    output logic [IDX_W-1:0]     rsp_win,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic [ATTR_W-1:0]    rsp_attr
);
    win_t [NUM_WIN-1:0]       tbl;
    logic [NUM_WIN-1:0]       hit_vec;
    logic [ADDR_W-1:0]        xaddr [NUM_WIN];
    logic                     any_hit;
    logic [IDX_W-1:0]         pick;
    logic                     accept;
    xlat_rsp_t                nxt, rsp_q;
    logic                     valid_q;

    axt_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata),
        .tbl   (tbl)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        axt_match u_match (
            .en    (tbl[i].en),
            .sz    (tbl[i].sz),
            .src   (tbl[i].src),
            .dst   (tbl[i].dst),
            .addr  (req_addr),
            .hit   (hit_vec[i]),
            .xaddr (xaddr[i])
        );
    end

    axt_pick u_pick (
        .hits (hit_vec),
        .any  (any_hit),
        .idx  (pick)
    );

    assign req_ready = !valid_q || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        nxt = '0;
        if (any_hit) begin
            nxt.hit  = 1'b1;
            nxt.win  = pick;
            nxt.addr = xaddr[pick];
            nxt.attr = tbl[pick].attr;
        end else begin
            nxt.addr = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else if (accept) begin
            valid_q <= 1'b1;
            rsp_q   <= nxt;
        end else if (rsp_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_win   = rsp_q.win;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_attr  = rsp_q.attr;

    // R10: a stalled response is held unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)
                                       && $stable(rsp_attr) && $stable(rsp_win)));

    // R10: an accepted request is answered on the next edge
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R8: a miss passes the request address through
    a_r8_passthru: assert property (@(posedge clk) disable iff (rst)
        (accept && !any_hit) |=> (!rsp_hit && rsp_addr == $past(req_addr) && rsp_attr == '0));

    // R7: the chosen window matches and no lower window does
    a_r7_lowest: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (hit_vec[pick] &&
                     ((hit_vec & ((NUM_WIN'(1) << pick) - NUM_WIN'(1))) == '0)));

    // R5: only an enabled window can be chosen
    a_r5_enabled: assert property (@(posedge clk) disable iff (rst)
        (accept && any_hit) |-> tbl[pick].en);

    // R6: bit 0 of the offset always comes from the request
    a_r6_offset_lsb: assert property (@(posedge clk) disable iff (rst)
        (accept && any_hit) |=> (rsp_hit && rsp_addr[0] == $past(req_addr[0])));
endmodule

// File: tb/addr_xlat_table_tb.sv
module addr_xlat_table_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_waddr;
    logic [31:0] reg_wdata;
    logic [7:0]  reg_raddr;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic        rsp_valid;
    logic        rsp_ready;
    logic        rsp_hit;
    logic [2:0]  rsp_win;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_attr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    addr_xlat_table u_dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_attr(rsp_attr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_raddr = a;
        #1 chk(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic lookup(input string req, input logic [63:0] a, input bit e_hit,
                          input logic [2:0] e_win, input logic [63:0] e_addr,
                          input logic [31:0] e_attr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " hit"},   64'(rsp_hit),   64'(e_hit));
        chk({req, " win"},   64'(rsp_win),   64'(e_win));
        chk({req, " addr"},  rsp_addr,       e_addr);
        chk({req, " attr"},  64'(rsp_attr),  64'(e_attr));
    endtask

    task automatic t_reset;
        chk("R1 src_lo after reset", 64'(reg_rdata), 64'd0);
        rd_chk("R1 attr after reset", 8'h10, 32'h0);
        chk("R10 ready after reset", 64'(req_ready), 64'd1);
        chk("R10 no rsp after reset", 64'(rsp_valid), 64'd0);
        lookup("R1 nothing matches", 64'h2c1c_0abc, 1'b0, 3'd0, 64'h2c1c_0abc, 32'h0);
    endtask

    task automatic t_program;
        // window 0: 4 KiB identity, f=11
        wr(8'h00, 32'h2c1c_0017); wr(8'h04, 32'h0);
        wr(8'h08, 32'h2c1c_0000); wr(8'h0C, 32'h0); wr(8'h10, 32'h0042_0004);
        // window 1: 256 MiB at 0x4000_0000 -> 0, f=27
        wr(8'h20, 32'h4000_0037); wr(8'h24, 32'h0);
        wr(8'h28, 32'h0);         wr(8'h2C, 32'h0); wr(8'h30, 32'h0000_0001);
        // window 2: 8 GiB at 0x40_0000_0000 -> 0x8_0000_0000, f=32
        wr(8'h40, 32'h0000_0041); wr(8'h44, 32'h40);
        wr(8'h48, 32'h0);         wr(8'h4C, 32'h8); wr(8'h50, 32'h004e_0004);
    endtask

    task automatic t_basic;
        lookup("R4 R6 win0 inside", 64'h2c1c_0abc, 1'b1, 3'd0, 64'h2c1c_0abc, 32'h0042_0004);
        lookup("R4 R8 win0 just past end", 64'h2c1c_1000, 1'b0, 3'd0, 64'h2c1c_1000, 32'h0);
        lookup("R6 win1 remap", 64'h4123_4567, 1'b1, 3'd1, 64'h0123_4567, 32'h1);
        lookup("R9 win2 8GiB", 64'h41_2345_6789, 1'b1, 3'd2, 64'h9_2345_6789, 32'h004e_0004);
        lookup("R9 R8 win2 beyond", 64'h42_0000_0000, 1'b0, 3'd0, 64'h42_0000_0000, 32'h0);
    endtask

    task automatic t_priority;
        // window 3: 1 GiB at 0x4000_0000 -> 0x1_0000_0000, overlaps window 1
        wr(8'h60, 32'h4000_003B); wr(8'h64, 32'h0);
        wr(8'h68, 32'h0); wr(8'h6C, 32'h1); wr(8'h70, 32'h0002_0000);
        lookup("R7 lower window wins", 64'h4123_4567, 1'b1, 3'd1, 64'h0123_4567, 32'h1);
        lookup("R7 only win3 covers", 64'h5000_0000, 1'b1, 3'd3, 64'h1_1000_0000, 32'h0002_0000);
        wr(8'h20, 32'h4000_0036);
        lookup("R5 disabled win1 skipped", 64'h4123_4567, 1'b1, 3'd3, 64'h1_0123_4567, 32'h0002_0000);
    endtask

    task automatic t_regs;
        wr(8'hE0, 32'hABCD_EFFE);
        rd_chk("R3 src_lo reserved zero", 8'hE0, 32'hABCD_E07E);
        wr(8'hE8, 32'h1234_5FFF);
        rd_chk("R3 dst_lo low bits zero", 8'hE8, 32'h1234_5000);
        wr(8'hE4, 32'hDEAD_BEEF);
        rd_chk("R2 src_hi readback", 8'hE4, 32'hDEAD_BEEF);
        wr(8'hEC, 32'hCAFE_F00D);
        rd_chk("R2 dst_hi readback", 8'hEC, 32'hCAFE_F00D);
        wr(8'hF0, 32'h0000_0055);
        rd_chk("R2 attr readback", 8'hF0, 32'h0000_0055);
        wr(8'hF4, 32'hFFFF_FFFF);
        rd_chk("R2 unused slot reads zero", 8'hF4, 32'h0);
        rd_chk("R2 unused slot no side effect", 8'hF0, 32'h0000_0055);
        rd_chk("R2 win1 src_lo readback", 8'h20, 32'h4000_0036);
        lookup("R5 win7 disabled", 64'hABCD_E123, 1'b0, 3'd0, 64'hABCD_E123, 32'h0);
    endtask

    task automatic t_stall;
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h2c1c_0010;
        @(negedge clk);
        chk("R10 valid one cycle later", 64'(rsp_valid), 64'd1);
        chk("R10 ready low while held", 64'(req_ready), 64'd0);
        req_addr = 64'h5000_0000;
        @(negedge clk);
        chk("R10 addr held in stall", rsp_addr, 64'h2c1c_0010);
        chk("R10 win held in stall", 64'(rsp_win), 64'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 next answer after release", rsp_addr, 64'h1_1000_0000);
        chk("R10 next win after release", 64'(rsp_win), 64'd3);
        @(negedge clk);
        chk("R10 valid drops when drained", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_whole_space;
        wr(8'hE0, 32'h0000_007F);
        wr(8'hE4, 32'h0); wr(8'hE8, 32'h0); wr(8'hEC, 32'h0);
        lookup("R9 f=63 covers everything", 64'hdead_0000_1234_5678, 1'b1, 3'd7,
               64'hdead_0000_1234_5678, 32'h55);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk("R1 win0 cleared", 8'h00, 32'h0);
        rd_chk("R1 win7 attr cleared", 8'hF0, 32'h0);
        lookup("R1 R8 miss after reset", 64'h2c1c_0abc, 1'b0, 3'd0, 64'h2c1c_0abc, 32'h0);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
        req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_program();
        t_basic();
        t_priority();
        t_regs();
        t_stall();
        t_whole_space();
        t_reset_again();
        done = 1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule